// File: doc/BRIEF.md
# Quarter-Period I2C Bit Engine

This block is the bit-level controller for a single-master I2C link. It drives an open-drain SCL/SDA pair through two output-enable pins (enable asserted pulls the wire low, deasserted lets it float high) and reads the wires back through a two-flop synchronizer. A caller issues one primitive at a time: START, STOP, WRITE of one byte with acknowledge sampling, or READ of one byte with an acknowledge or not-acknowledge driven afterwards. Each primitive ends with a one-cycle `done` pulse. Alongside it the block reports a pass/fail flag, a separate timeout flag, the acknowledge it sampled and the received byte.

All timing is counted in quarter bit periods. A quarter lasts `quarter_div` system clocks. That value is captured when a command is accepted, and values below a floor are raised to the floor. Each time the engine releases SCL it waits one quarter and then polls the wire once per quarter until SCL reads high, so a target that stretches the clock is honoured. If the poll count runs past a fixed limit, the primitive is abandoned. START retries while SDA is held low. STOP confirms that SDA has returned high.

Top module: `i2c_quarter_engine`

## Requirements
- R1: After reset both output enables are 0 (lines released), and `busy` and `done` are 0.
- R2: `quarter_div` is captured on command acceptance, so later changes during the command have no effect on its timing. A captured value below MIN_QDIV (default 3) behaves exactly as MIN_QDIV, and a larger value stretches the command proportionally.
- R3: START (`cmd_op`=0) with free lines makes SDA fall while SCL is high, ends with both lines driven low, and reports `ok`=1.
- R4: If SDA does not read high after release during START, the engine retries up to START_TRIES attempts. It then ends with `ok`=0 and `timeout_err`=0. A later START on free lines succeeds.
- R5: WRITE (`cmd_op`=2) shifts `cmd_byte` out MSB first. SDA changes only while SCL is driven low, so each bit is stable at its SCL rise.
- R6: At the ninth SCL pulse of a WRITE, SDA low gives `ack_seen`=1 and `ok`=1, and SDA high gives `ack_seen`=0 and `ok`=0.
- R7: READ (`cmd_op`=3) samples SDA at eight SCL high phases, MSB first, and presents the whole byte on `rx_byte`.
- R8: After the eighth read bit, the engine drives SDA for a ninth SCL pulse. SDA is low (acknowledge) when `cmd_nack`=0 and high when `cmd_nack`=1.
- R9: STOP (`cmd_op`=1) makes SDA rise while SCL is high, leaves both lines released, and reports `ok`=1.
- R10: If SDA does not read high within three quarter-spaced samples after the STOP release, the result is `ok`=0 with `timeout_err`=0.
- R11: A target holding SCL low for fewer polls than STRETCH_LIMIT delays the primitive, which then completes with `ok`=1.
- R12: If SCL is still low after STRETCH_LIMIT+1 polls, the primitive ends at once with `timeout_err`=1 and `ok`=0, without waiting for SCL.
- R13: `done` is a single-cycle pulse, one per accepted command. `cmd_valid` while `busy` is ignored and does not disturb the running primitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmd_byte | input | 8 | Byte to transmit for WRITE |
| cmd_nack | input | 1 | For READ: 1 sends not-acknowledge (last byte) |
| quarter_div | input | QW | System clocks per quarter bit period |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Primitive in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Result of the last primitive |
| timeout_err | output | 1 | Last primitive aborted on clock-stretch timeout |
| ack_seen | output | 1 | Acknowledge sampled by the last WRITE |
| rx_byte | output | 8 | Byte received by the last READ |

## Verification
The bench sends every byte value through WRITE and READ and derives the expected serial bits, acknowledges and received data arithmetically. An engine that shifted LSB first or sampled at the wrong SCL phase would corrupt the bytes, and one that inverted the acknowledge would flip `ok`. A target that holds SDA low probes the START retry and the STOP confirmation, where a design that skipped them would report success. A target that holds SCL low for short and long stretches shows whether the engine waits and whether it gives up on time. Timing comparisons across divisor values and a mid-command divisor change expose a missing floor or a divisor that is not latched.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [4:0] {
    S_IDLE, S_POLL, S_FIN,
    S_ST0, S_ST1, S_ST2, S_ST3, S_ST4,
    S_SP0, S_SP1, S_SP2, S_SP3, S_SP4,
    S_W1, S_W2, S_W3,
    S_WA1, S_WA2, S_WA3, S_WA4,
    S_R0, S_R1,
    S_RA0, S_RA1, S_RA2, S_RA3
  } st_e;

endpackage

// File: rtl/i2cq_sync.sv
module i2cq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] r;
    always_ff @(posedge clk) begin
      if (rst) r <= '1;
      else     r <= {r[STAGES-2:0], d[i]};
    end
    assign q[i] = r[STAGES-1];
  end
endmodule

// File: rtl/i2cq_qtick.sv
module i2cq_qtick #(
  parameter int QW       = 8,
  parameter int MIN_QDIV = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [QW-1:0] div_in,
  input  logic          run,
  input  logic          restart,
  output logic          tick
);
  localparam logic [QW-1:0] FLOOR = QW'(MIN_QDIV);

  logic [QW-1:0] qdiv_q;
  logic [QW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       qdiv_q <= FLOOR;
    else if (load) qdiv_q <= (div_in < FLOOR) ? FLOOR : div_in;
  end

  assign tick = run && (cnt == qdiv_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart || !run || tick) cnt <= '0;
    else                                cnt <= cnt + 1'b1;
  end

  AST_DIV_LATCHED: assert property (@(posedge clk) disable iff (rst)
    run && $past(run) |-> $stable(qdiv_q)); // R2

endmodule

// File: rtl/i2c_quarter_engine.sv
module i2c_quarter_engine
  import i2cq_pkg::*;
#(
  parameter int QW            = 8,
  parameter int MIN_QDIV      = 3,
  parameter int STRETCH_LIMIT = 1000,
  parameter int START_TRIES   = 3,
  parameter int STOP_TRIES    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [7:0]    cmd_byte,
  input  logic          cmd_nack,
  input  logic [QW-1:0] quarter_div,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic          done,
  output logic          ok,
  output logic          timeout_err,
  output logic          ack_seen,
  output logic [7:0]    rx_byte
);
  localparam int PW    = $clog2(STRETCH_LIMIT + 1);
  localparam int MAXT  = (START_TRIES > STOP_TRIES) ? START_TRIES : STOP_TRIES;
  localparam int TW    = $clog2(MAXT + 1);

  st_e          st, ret;
  op_e          op_q;
  logic [1:0]   wcnt;
  logic         go_now;
  logic [PW-1:0] pcnt;
  logic [TW-1:0] tries;
  logic [2:0]   bitn;
  logic [7:0]   sh;
  logic         nack_q, good_q;
  logic         scl_s, sda_s;
  logic         tick, step, accept;

  i2cq_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  assign accept = !busy && cmd_valid;
  assign step   = busy && (go_now || (tick && (wcnt == 2'd0)));

  i2cq_qtick #(.QW(QW), .MIN_QDIV(MIN_QDIV)) u_tick (
    .clk(clk), .rst(rst), .load(accept), .div_in(quarter_div),
    .run(busy), .restart(step), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ret <= S_IDLE; op_q <= OP_START;
      wcnt <= '0; go_now <= 1'b0; pcnt <= '0; tries <= '0; bitn <= '0;
      sh <= '0; nack_q <= 1'b0; good_q <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0; busy <= 1'b0; done <= 1'b0;
      ok <= 1'b0; timeout_err <= 1'b0; ack_seen <= 1'b0; rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1; op_q <= op_e'(cmd_op); sh <= cmd_byte; nack_q <= cmd_nack;
        bitn <= 3'd7; tries <= '0; pcnt <= '0; wcnt <= '0; go_now <= 1'b0;
        good_q <= 1'b1; ok <= 1'b0; timeout_err <= 1'b0;
        case (op_e'(cmd_op))
          OP_START: st <= S_ST0;
          OP_STOP:  st <= S_SP0;
          OP_WRITE: st <= S_W1;
          default: begin st <= S_R0; sda_oe <= 1'b0; end
        endcase
      end else if (step) begin
        go_now <= 1'b0;
        case (st)
          S_POLL:
            if (scl_s) begin st <= ret; go_now <= 1'b1; end
            else if (pcnt == PW'(STRETCH_LIMIT)) begin
              busy <= 1'b0; done <= 1'b1; ok <= 1'b0; timeout_err <= 1'b1; st <= S_IDLE;
            end else pcnt <= pcnt + 1'b1;
          S_FIN: begin busy <= 1'b0; done <= 1'b1; ok <= good_q; st <= S_IDLE; end
          // start condition
          S_ST0: begin scl_oe <= 1'b0; st <= S_ST1; end
          S_ST1: begin sda_oe <= 1'b0; st <= S_ST2; end
          S_ST2:
            if (!sda_s) begin
              if (tries == TW'(START_TRIES - 1)) begin
                busy <= 1'b0; done <= 1'b1; ok <= 1'b0; st <= S_IDLE;
              end else begin tries <= tries + 1'b1; st <= S_ST1; end
            end else begin
              scl_oe <= 1'b0; st <= S_POLL; ret <= S_ST3; pcnt <= '0;
            end
          S_ST3: begin sda_oe <= 1'b1; st <= S_ST4; end
          S_ST4: begin scl_oe <= 1'b1; st <= S_FIN; end
          // stop condition
          S_SP0: begin scl_oe <= 1'b1; st <= S_SP1; end
          S_SP1: begin sda_oe <= 1'b1; st <= S_SP2; end
          S_SP2: begin scl_oe <= 1'b0; st <= S_POLL; ret <= S_SP3; pcnt <= '0; end
          S_SP3: begin sda_oe <= 1'b0; st <= S_SP4; end
          S_SP4:
            if (sda_s) begin
              busy <= 1'b0; done <= 1'b1; ok <= 1'b1; st <= S_IDLE;
            end else if (tries == TW'(STOP_TRIES - 1)) begin
              busy <= 1'b0; done <= 1'b1; ok <= 1'b0; st <= S_IDLE;
            end else tries <= tries + 1'b1;
          // byte write
          S_W1: begin sda_oe <= !sh[7]; st <= S_W2; end
          S_W2: begin scl_oe <= 1'b0; st <= S_POLL; ret <= S_W3; pcnt <= '0; end
          S_W3: begin
            scl_oe <= 1'b1; sh <= {sh[6:0], 1'b0};
            if (bitn == 3'd0) st <= S_WA1;
            else begin bitn <= bitn - 1'b1; st <= S_W1; end
          end
          S_WA1: begin sda_oe <= 1'b0; st <= S_WA2; end
          S_WA2: begin scl_oe <= 1'b0; st <= S_POLL; ret <= S_WA3; pcnt <= '0; end
          S_WA3: begin ack_seen <= !sda_s; good_q <= !sda_s; wcnt <= 2'd1; st <= S_WA4; end
          S_WA4: begin scl_oe <= 1'b1; wcnt <= 2'd1; st <= S_FIN; end
          // byte read
          S_R0: begin scl_oe <= 1'b0; st <= S_POLL; ret <= S_R1; pcnt <= '0; end
          S_R1: begin
            sh <= {sh[6:0], sda_s}; scl_oe <= 1'b1;
            if (bitn == 3'd0) begin wcnt <= 2'd2; st <= S_RA0; end
            else begin wcnt <= 2'd1; bitn <= bitn - 1'b1; st <= S_R0; end
          end
          S_RA0: begin rx_byte <= sh; sda_oe <= !nack_q; st <= S_RA1; end
          S_RA1: begin scl_oe <= 1'b0; st <= S_POLL; ret <= S_RA2; pcnt <= '0; end
          S_RA2: begin scl_oe <= 1'b1; st <= S_RA3; end
          S_RA3: begin sda_oe <= 1'b0; st <= S_FIN; end
          default: begin busy <= 1'b0; st <= S_IDLE; end
        endcase
      end else if (busy && tick && (wcnt != 2'd0)) begin
        wcnt <= wcnt - 1'b1;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !scl_oe && !sda_oe && !busy && !done); // R1
  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) && (op_q == OP_WRITE || op_q == OP_READ) && !$stable(sda_oe)
    |-> scl_oe); // R5
  AST_ACK_RESULT: assert property (@(posedge clk) disable iff (rst)
    done && (op_q == OP_WRITE) && !timeout_err |-> ok == ack_seen); // R6
  AST_TIMEOUT_FAILS: assert property (@(posedge clk) disable iff (rst)
    done && timeout_err |-> !ok); // R12
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
    pcnt <= PW'(STRETCH_LIMIT)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R13

endmodule

// File: tb/i2c_quarter_engine_test.sv
`timescale 1ns/1ps
module i2c_quarter_engine_test;
  localparam int QW  = 8;
  localparam int LIM = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_byte = 8'd0;
  logic cmd_nack = 1'b0;
  logic [QW-1:0] quarter_div = 8'd3;
  logic scl_oe, sda_oe, busy, done, ok, timeout_err, ack_seen;
  logic [7:0] rx_byte;

  // target model
  logic sda_force = 1'b0, ack_en = 1'b0, fc_clr = 1'b0, hold_load = 1'b0;
  int   tmode = 0, fc = 0, hold_cnt = 0, hold_val = 0, nrise = 0;
  logic [7:0] tx_byte = 8'd0;
  logic [8:0] cap = '0;
  logic start_seen = 1'b0, stop_seen = 1'b0, prev_scl = 1'b1, prev_sda = 1'b1;
  logic sda_model, scl_l, sda_l;

  always_comb begin
    sda_model = 1'b0;
    if (tmode == 1 && ack_en && fc == 8) sda_model = 1'b1;
    if (tmode == 2 && fc < 8) sda_model = !tx_byte[3'(7 - fc)];
  end
  assign scl_l = !(scl_oe || (hold_cnt != 0));
  assign sda_l = !(sda_oe || sda_force || sda_model);

  always @(posedge clk) begin
    if (fc_clr) begin
      fc <= 0; nrise <= 0; cap <= '0; start_seen <= 1'b0; stop_seen <= 1'b0;
    end else begin
      if (prev_scl && !scl_l) fc <= fc + 1;
      if (!prev_scl && scl_l) begin cap <= {cap[7:0], sda_l}; nrise <= nrise + 1; end
      if (scl_l && prev_scl && prev_sda && !sda_l) start_seen <= 1'b1;
      if (scl_l && prev_scl && !prev_sda && sda_l) stop_seen <= 1'b1;
    end
    prev_scl <= scl_l; prev_sda <= sda_l;
    if (hold_load) hold_cnt <= hold_val;
    else if (hold_cnt > 0) hold_cnt <= hold_cnt - 1;
  end

  i2c_quarter_engine #(.QW(QW), .MIN_QDIV(3), .STRETCH_LIMIT(LIM),
                       .START_TRIES(3), .STOP_TRIES(3)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_nack(cmd_nack), .quarter_div(quarter_div),
    .scl_i(scl_l), .sda_i(sda_l), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .done(done), .ok(ok), .timeout_err(timeout_err),
    .ack_seen(ack_seen), .rx_byte(rx_byte)
  );

  int nvec = 0, nfail = 0;

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] b, input logic nk,
                         input int hold, input int newdiv, input bit poke, output int dur);
    @(negedge clk);
    cmd_op = op; cmd_byte = b; cmd_nack = nk; cmd_valid = 1'b1;
    fc_clr = 1'b1; hold_load = 1'b1; hold_val = hold;
    @(negedge clk);
    cmd_valid = 1'b0; fc_clr = 1'b0; hold_load = 1'b0;
    if (newdiv > 0) quarter_div = QW'(newdiv);
    dur = 1;
    while (!done && dur < 5000) begin
      @(negedge clk);
      dur++;
      if (poke && dur == 10) begin cmd_valid = 1'b1; cmd_op = 2'd0; end
      else cmd_valid = 1'b0;
    end
    cmd_valid = 1'b0;
    if (dur >= 5000) chk("watchdog command", 0, 1);
  endtask

  initial begin
    #(8 * 190000);
    chk("watchdog global", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int d, d_stop, d3, d1, d6, dl, extra;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 scl_oe", scl_oe, 0); chk("R1 sda_oe", sda_oe, 0);
    chk("R1 busy", busy, 0);     chk("R1 done", done, 0);

    // R3 start
    run_cmd(2'd0, 8'd0, 1'b0, 0, 0, 1'b0, d);
    chk("R3 ok", ok, 1); chk("R3 start_seen", start_seen, 1);
    chk("R3 scl_oe", scl_oe, 1); chk("R3 sda_oe", sda_oe, 1);

    // R5 R6 write sweep
    tmode = 1;
    for (int b = 0; b < 256; b++) begin
      ack_en = (b % 3) != 0;
      run_cmd(2'd2, 8'(b), 1'b0, 0, 0, 1'b0, d);
      chk("R5 pulses", nrise, 9);
      chk("R5 byte", int'(cap[8:1]), b);
      chk("R6 ack_seen", ack_seen, int'(ack_en));
      chk("R6 ok", ok, int'(ack_en));
    end

    // R7 R8 read sweep
    tmode = 2;
    for (int b = 0; b < 256; b++) begin
      tx_byte = 8'(b);
      run_cmd(2'd3, 8'd0, b[0], 0, 0, 1'b0, d);
      chk("R7 rx_byte", rx_byte, b);
      chk("R8 pulses", nrise, 9);
      chk("R8 ack bit", int'(cap[0]), b & 1);
    end

    // R9 stop
    tmode = 0;
    run_cmd(2'd1, 8'd0, 1'b0, 0, 0, 1'b0, d_stop);
    chk("R9 ok", ok, 1); chk("R9 stop_seen", stop_seen, 1);
    chk("R9 scl_oe", scl_oe, 0); chk("R9 sda_oe", sda_oe, 0);

    // R4 start retry
    sda_force = 1'b1;
    run_cmd(2'd0, 8'd0, 1'b0, 0, 0, 1'b0, d);
    chk("R4 ok", ok, 0); chk("R4 timeout_err", timeout_err, 0);
    chk("R4 start_seen", start_seen, 0);
    sda_force = 1'b0;
    run_cmd(2'd0, 8'd0, 1'b0, 0, 0, 1'b0, d);
    chk("R4 recover ok", ok, 1);

    // R10 stop with stuck SDA
    sda_force = 1'b1;
    run_cmd(2'd1, 8'd0, 1'b0, 0, 0, 1'b0, d);
    chk("R10 ok", ok, 0); chk("R10 timeout_err", timeout_err, 0);
    sda_force = 1'b0;
    repeat (10) @(negedge clk);

    // R11 short stretch
    run_cmd(2'd0, 8'd0, 1'b0, 0, 0, 1'b0, d);
    run_cmd(2'd1, 8'd0, 1'b0, 60, 0, 1'b0, d);
    chk("R11 ok", ok, 1); chk("R11 stop_seen", stop_seen, 1);
    chk("R11 delayed", int'(d > d_stop + 40), 1);

    // R12 long stretch
    run_cmd(2'd0, 8'd0, 1'b0, 0, 0, 1'b0, d);
    run_cmd(2'd1, 8'd0, 1'b0, 400, 0, 1'b0, d);
    chk("R12 timeout_err", timeout_err, 1); chk("R12 ok", ok, 0);
    chk("R12 aborted early", int'(d < 400), 1);
    chk("R12 full poll window", int'(d >= LIM * 3), 1);
    chk("R12 busy", busy, 0);
    repeat (420) @(negedge clk);

    // R2 divisor floor and latch
    run_cmd(2'd0, 8'd0, 1'b0, 0, 0, 1'b0, d);
    tmode = 1; ack_en = 1'b1;
    quarter_div = 8'd3; run_cmd(2'd2, 8'h5A, 1'b0, 0, 0, 1'b0, d3);
    quarter_div = 8'd1; run_cmd(2'd2, 8'h5A, 1'b0, 0, 0, 1'b0, d1);
    chk("R2 floor", d1, d3);
    quarter_div = 8'd6; run_cmd(2'd2, 8'h5A, 1'b0, 0, 0, 1'b0, d6);
    chk("R2 scaling", int'(d6 > d3 + d3 / 2), 1);
    quarter_div = 8'd3; run_cmd(2'd2, 8'h5A, 1'b0, 0, 9, 1'b0, dl);
    chk("R2 latched", dl, d3);
    quarter_div = 8'd3;

    // R13 ignore cmd_valid while busy, single done pulse
    run_cmd(2'd2, 8'hC3, 1'b0, 0, 0, 1'b1, d);
    chk("R13 byte undisturbed", int'(cap[8:1]), 8'hC3);
    chk("R13 ok", ok, 1);
    chk("R13 duration", d, d3);
    extra = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R13 extra done pulses", extra, 0);
    chk("R13 idle", busy, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule